// File: doc/BRIEF.md
# Dual-Channel Modem Status Capture

This block captures the modem control inputs for both channels of a two-channel serial bridge. Each channel has four active-low control lines: carrier detect, ring indicator, data-set ready and clear-to-send. Each line passes through a two-flop synchronizer. Each channel presents an 8-bit status word. The upper nibble gives the present state of the lines, active high. The lower nibble holds sticky change flags, and a per-channel read strobe clears them.

Clear-to-send always has a dedicated pin. The other three lines borrow general-purpose pins, and only do so while that channel's modem-pin enable is high. Channel A uses pins 4, 6 and 7, and channel B uses pins 0, 2 and 3. The block also returns the synchronized general-purpose pin levels. A pin that currently serves as a modem input reads 0 there, so software must use the status word to see that pin. A per-channel interrupt request is raised while any change flag is set and that channel's interrupt enable is high.

Each channel runs a two-state controller:
- FILL is entered at reset. It lasts for the synchronizer depth plus one cycle, and no flags can set during it.
- The transition FILL to RUN happens when the fill counter expires.
- RUN is permanent until the next reset, and edge detection is armed while in RUN.

Top module: `mdm_stat_dual`

## Requirements
- R1: Status bit 4 is the complement of the channel's clear-to-send pin. It takes that value after the pin level has passed two clock edges.
- R2: When the channel's modem-pin enable is high, status bits 7, 6 and 5 are the complements of the carrier-detect, ring and data-set-ready pins. Channel A reads these from general-purpose pins 6, 7 and 4. Channel B reads them from pins 2, 3 and 0.
- R3: When the modem-pin enable is low, status bits 7 to 5 read 0. When it is low, flags 3 to 1 do not set. Flags 3 to 1 also do not set in the cycle in which the enable changes.
- R4: Flag bit 3 (carrier detect) sets when its line changes in either direction. So do flag bit 1 (data-set ready) and flag bit 0 (clear-to-send).
- R5: Flag bit 2 sets only when the ring pin goes from low to high, which is when status bit 6 falls. A high-to-low change of the ring pin leaves it clear.
- R6: A read strobe returns the current status word in the same cycle. Bits 3 to 0 are clear from the next cycle on.
- R7: A change detected in the same cycle as a read is not shown by that read, and its flag is set afterwards.
- R8: A set flag stays set until the channel is read.
- R9: The interrupt request of a channel is high exactly when its interrupt enable is high and any of its bits 3 to 0 is set.
- R10: The pin-state output carries the synchronized general-purpose pin levels, except that pins in modem use read 0.
- R11: After reset the status words read 0 for pins held inactive. No flag sets during the first three cycles after reset, even if a pin is held active through reset.
- R12: A read of one channel does not alter the other channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_pin_i | input | 8 | Raw general-purpose pins |
| cts_n_a_i | input | 1 | Channel A clear-to-send pin, active low |
| cts_n_b_i | input | 1 | Channel B clear-to-send pin, active low |
| modem_en_a_i | input | 1 | Channel A uses its shared pins as modem inputs |
| modem_en_b_i | input | 1 | Channel B uses its shared pins as modem inputs |
| msi_en_a_i | input | 1 | Channel A status interrupt enable |
| msi_en_b_i | input | 1 | Channel B status interrupt enable |
| rd_a_i | input | 1 | Channel A status read strobe |
| rd_b_i | input | 1 | Channel B status read strobe |
| msr_a_o | output | 8 | Channel A status word |
| msr_b_o | output | 8 | Channel B status word |
| irq_a_o | output | 1 | Channel A interrupt request |
| irq_b_o | output | 1 | Channel B interrupt request |
| gpio_state_o | output | 8 | Synchronized pin levels, modem pins masked |

## Verification
The assertions check several properties on every cycle:
- the clear-to-send bit tracks its pin two edges late;
- shared status bits stay 0 while the enable is low;
- flags only fall when a read was made;
- the ring flag only rises after a fall of the ring status bit;
- the interrupt request agrees with its enable and the flags;
- modem-owned pins are masked in the pin-state output.

Some behaviours only the bench's scenarios can show:
- the exact pin mapping per channel;
- suppression of flags when the enable changes;
- a change that coincides with a read;
- channel independence;
- the quiet fill period after reset.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;

    // Bit offsets of the shared lines relative to a channel's pin base
    localparam int OFS_DSR = 0;
    localparam int OFS_CD  = 2;
    localparam int OFS_RI  = 3;

    // Status word layout (decoded by software, so positions are fixed)
    localparam int MSR_W    = 8;
    localparam int FLAG_W   = 4;

    // Per-channel controller states
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } chan_st_e;

    // Active-high line levels, ordered as status bits 7..4
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int              W       = 10,
    parameter int              STAGES  = 2,
    parameter logic            RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= {W{RST_VAL}};
                    else        stg_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= {W{RST_VAL}};
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mdm_pin_route.sv
module mdm_pin_route
    import mdm_stat_pkg::*;
#(
    parameter int GPIO_W = 8,
    parameter int A_BASE = 4,
    parameter int B_BASE = 0
) (
    input  logic [GPIO_W-1:0] gpio_sync_i,
    input  logic              cts_n_a_sync_i,
    input  logic              cts_n_b_sync_i,
    input  logic              en_a_i,
    input  logic              en_b_i,
    output mdm_lines_t        lines_a_o,
    output mdm_lines_t        lines_b_o,
    output logic [GPIO_W-1:0] gpio_state_o
);

    localparam logic [GPIO_W-1:0] ONE    = GPIO_W'(1);
    localparam logic [GPIO_W-1:0] MASK_A = (ONE << (A_BASE + OFS_DSR)) |
                                           (ONE << (A_BASE + OFS_CD))  |
                                           (ONE << (A_BASE + OFS_RI));
    localparam logic [GPIO_W-1:0] MASK_B = (ONE << (B_BASE + OFS_DSR)) |
                                           (ONE << (B_BASE + OFS_CD))  |
                                           (ONE << (B_BASE + OFS_RI));

    always_comb begin
        // Channel A: inverted and gated by the modem-pin enable
        lines_a_o.cd  = en_a_i & ~gpio_sync_i[A_BASE + OFS_CD];
        lines_a_o.ri  = en_a_i & ~gpio_sync_i[A_BASE + OFS_RI];
        lines_a_o.dsr = en_a_i & ~gpio_sync_i[A_BASE + OFS_DSR];
        lines_a_o.cts = ~cts_n_a_sync_i;

        // Channel B
        lines_b_o.cd  = en_b_i & ~gpio_sync_i[B_BASE + OFS_CD];
        lines_b_o.ri  = en_b_i & ~gpio_sync_i[B_BASE + OFS_RI];
        lines_b_o.dsr = en_b_i & ~gpio_sync_i[B_BASE + OFS_DSR];
        lines_b_o.cts = ~cts_n_b_sync_i;

        // Pins serving as modem inputs are hidden from the pin-state view
        gpio_state_o = gpio_sync_i
                     & ~({GPIO_W{en_a_i}} & MASK_A)
                     & ~({GPIO_W{en_b_i}} & MASK_B);
    end

endmodule

// File: rtl/mdm_chan.sv
module mdm_chan
    import mdm_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mdm_lines_t       lines_i,
    input  logic             en_i,
    input  logic             rd_i,
    input  logic             ie_i,
    output logic [MSR_W-1:0] msr_o,
    output logic             irq_o
);

    localparam int FILL_CYC = SYNC_STAGES + 1;
    localparam int CNT_W    = $clog2(FILL_CYC + 1);

    chan_st_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    mdm_lines_t        prev_q;
    logic              en_q;
    logic [FLAG_W-1:0] flg_q, flg_d;
    logic [FLAG_W-1:0] edge_raw, edge_ok;
    logic              share_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FILL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_FILL: begin
                if (cnt_q == CNT_W'(FILL_CYC - 1)) begin
                    st_d  = ST_RUN;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_RUN: begin
                st_d = ST_RUN;
            end
        endcase
    end

    // Edge detection and flag update
    always_comb begin
        edge_raw[3] = lines_i.cd  ^ prev_q.cd;
        edge_raw[2] = prev_q.ri   & ~lines_i.ri;   // ring pin low-to-high
        edge_raw[1] = lines_i.dsr ^ prev_q.dsr;
        edge_raw[0] = lines_i.cts ^ prev_q.cts;

        share_ok = en_i & (en_i == en_q);

        if (st_q == ST_RUN)
            edge_ok = edge_raw & {share_ok, share_ok, share_ok, 1'b1};
        else
            edge_ok = '0;

        flg_d = (flg_q & ~{FLAG_W{rd_i}}) | edge_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            en_q   <= 1'b0;
            flg_q  <= '0;
        end else begin
            prev_q <= lines_i;
            en_q   <= en_i;
            flg_q  <= flg_d;
        end
    end

    // Outputs
    always_comb begin
        msr_o = {lines_i, flg_q};
        irq_o = ie_i & (|flg_q);
    end

endmodule

// File: rtl/mdm_stat_dual.sv
module mdm_stat_dual
    import mdm_stat_pkg::*;
#(
    parameter int GPIO_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int A_BASE      = 4,
    parameter int B_BASE      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] gpio_pin_i,
    input  logic              cts_n_a_i,
    input  logic              cts_n_b_i,
    input  logic              modem_en_a_i,
    input  logic              modem_en_b_i,
    input  logic              msi_en_a_i,
    input  logic              msi_en_b_i,
    input  logic              rd_a_i,
    input  logic              rd_b_i,
    output logic [MSR_W-1:0]  msr_a_o,
    output logic [MSR_W-1:0]  msr_b_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic [GPIO_W-1:0] gpio_state_o
);

    localparam int SW = GPIO_W + 2;

    logic [SW-1:0]     pins_sync;
    mdm_lines_t        lines_a, lines_b;

    mdm_sync #(
        .W       (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cts_n_b_i, cts_n_a_i, gpio_pin_i}),
        .q_o   (pins_sync)
    );

    mdm_pin_route #(
        .GPIO_W (GPIO_W),
        .A_BASE (A_BASE),
        .B_BASE (B_BASE)
    ) u_route (
        .gpio_sync_i    (pins_sync[GPIO_W-1:0]),
        .cts_n_a_sync_i (pins_sync[GPIO_W]),
        .cts_n_b_sync_i (pins_sync[GPIO_W+1]),
        .en_a_i         (modem_en_a_i),
        .en_b_i         (modem_en_b_i),
        .lines_a_o      (lines_a),
        .lines_b_o      (lines_b),
        .gpio_state_o   (gpio_state_o)
    );

    mdm_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines_a),
        .en_i    (modem_en_a_i),
        .rd_i    (rd_a_i),
        .ie_i    (msi_en_a_i),
        .msr_o   (msr_a_o),
        .irq_o   (irq_a_o)
    );

    mdm_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines_b),
        .en_i    (modem_en_b_i),
        .rd_i    (rd_b_i),
        .ie_i    (msi_en_b_i),
        .msr_o   (msr_b_o),
        .irq_o   (irq_b_o)
    );

endmodule

// File: rtl/mdm_stat_chk.sv
module mdm_stat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cts_n_a_i,
    input logic       cts_n_b_i,
    input logic       modem_en_a_i,
    input logic       modem_en_b_i,
    input logic       msi_en_a_i,
    input logic       msi_en_b_i,
    input logic       rd_a_i,
    input logic       rd_b_i,
    input logic [7:0] msr_a_o,
    input logic [7:0] msr_b_o,
    input logic       irq_a_o,
    input logic       irq_b_o,
    input logic [7:0] gpio_state_o
);

    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_CTS_TRACK_A: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (msr_a_o[4] == !$past(cts_n_a_i, 2))); // R1
    AST_CTS_TRACK_B: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (msr_b_o[4] == !$past(cts_n_b_i, 2))); // R1

    AST_SHARED_OFF_A: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_en_a_i |-> (msr_a_o[7:5] == 3'b000)); // R3
    AST_SHARED_OFF_B: assert property (@(posedge clk) disable iff (!rst_n)
        !modem_en_b_i |-> (msr_b_o[7:5] == 3'b000)); // R3

    AST_RI_ONE_WAY_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msr_a_o[2]) |-> ($past(msr_a_o[6], 2) && !$past(msr_a_o[6]))); // R5

    AST_STICKY_A: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_a_i) |-> ((msr_a_o[3:0] & $past(msr_a_o[3:0])) == $past(msr_a_o[3:0]))); // R8
    AST_STICKY_B: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_b_i) |-> ((msr_b_o[3:0] & $past(msr_b_o[3:0])) == $past(msr_b_o[3:0]))); // R8

    AST_IRQ_GATE_A: assert property (@(posedge clk) disable iff (!rst_n)
        irq_a_o |-> msi_en_a_i); // R9
    AST_IRQ_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en_b_i && (msr_b_o[3:0] != 4'd0)) |-> irq_b_o); // R9

    AST_PIN_MASK_A: assert property (@(posedge clk) disable iff (!rst_n)
        modem_en_a_i |-> (gpio_state_o[7:6] == 2'b00 && !gpio_state_o[4])); // R10
    AST_PIN_MASK_B: assert property (@(posedge clk) disable iff (!rst_n)
        modem_en_b_i |-> (gpio_state_o[3:2] == 2'b00 && !gpio_state_o[0])); // R10

endmodule

bind mdm_stat_dual mdm_stat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cts_n_a_i    (cts_n_a_i),
    .cts_n_b_i    (cts_n_b_i),
    .modem_en_a_i (modem_en_a_i),
    .modem_en_b_i (modem_en_b_i),
    .msi_en_a_i   (msi_en_a_i),
    .msi_en_b_i   (msi_en_b_i),
    .rd_a_i       (rd_a_i),
    .rd_b_i       (rd_b_i),
    .msr_a_o      (msr_a_o),
    .msr_b_o      (msr_b_o),
    .irq_a_o      (irq_a_o),
    .irq_b_o      (irq_b_o),
    .gpio_state_o (gpio_state_o)
);

// File: tb/mdm_stat_dual_tb.sv
module mdm_stat_dual_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gpio_pin = 8'hFF;
    logic       cts_n_a = 1'b1, cts_n_b = 1'b1;
    logic       en_a = 1'b0, en_b = 1'b0;
    logic       ie_a = 1'b0, ie_b = 1'b0;
    logic       rd_a = 1'b0, rd_b = 1'b0;
    logic [7:0] msr_a, msr_b, gstate;
    logic       irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdm_stat_dual dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .gpio_pin_i   (gpio_pin),
        .cts_n_a_i    (cts_n_a),
        .cts_n_b_i    (cts_n_b),
        .modem_en_a_i (en_a),
        .modem_en_b_i (en_b),
        .msi_en_a_i   (ie_a),
        .msi_en_b_i   (ie_b),
        .rd_a_i       (rd_a),
        .rd_b_i       (rd_b),
        .msr_a_o      (msr_a),
        .msr_b_o      (msr_b),
        .irq_a_o      (irq_a),
        .irq_b_o      (irq_b),
        .gpio_state_o (gstate)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Pin change driven at a falling edge becomes visible in the flags after three rising edges
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_a(output logic [7:0] v);
        rd_a = 1'b1; #1; v = msr_a;
        @(posedge clk); @(negedge clk); rd_a = 1'b0;
    endtask

    task automatic read_b(output logic [7:0] v);
        rd_b = 1'b1; #1; v = msr_b;
        @(posedge clk); @(negedge clk); rd_b = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 msr_a after reset", msr_a, 8'h00);
        check("R11 msr_b after reset", msr_b, 8'h00);
        check("R9 irq idle", {6'd0, irq_b, irq_a}, 8'h00);
        check("R10 pin state idle", gstate, 8'hFF);
    endtask

    task automatic t_cts();
        logic [7:0] v;
        cts_n_a = 1'b0; settle();
        check("R1 cts level", msr_a & 8'h10, 8'h10);
        check("R4 cts flag fall", msr_a & 8'h0F, 8'h01);
        read_a(v);
        check("R6 read returns flags", v, 8'h11);
        check("R6 flags cleared", msr_a, 8'h10);
        cts_n_a = 1'b1; settle();
        check("R4 cts flag rise", msr_a, 8'h01);
        read_a(v);
    endtask

    task automatic t_shared_a();
        logic [7:0] v;
        en_a = 1'b1; @(negedge clk); @(negedge clk);
        check("R3 enable switch no flag", msr_a, 8'h00);
        gpio_pin[6] = 1'b0; settle();
        check("R2 cd on pin6", msr_a, 8'h88);
        check("R10 masked pins A", gstate, 8'h2F);
        read_a(v);
        gpio_pin[4] = 1'b0; settle();
        check("R2 dsr on pin4", msr_a, 8'hA2);
        read_a(v);
        gpio_pin[6] = 1'b1; gpio_pin[4] = 1'b1; settle();
        check("R4 cd dsr release", msr_a, 8'h0A);
        read_a(v);
    endtask

    task automatic t_ri();
        logic [7:0] v;
        gpio_pin[7] = 1'b0; settle();
        check("R5 ri falling pin no flag", msr_a, 8'h40);
        gpio_pin[7] = 1'b1; settle();
        check("R5 ri rising pin flag", msr_a, 8'h04);
        read_a(v);
    endtask

    task automatic t_disabled_b();
        gpio_pin[0] = 1'b0; gpio_pin[2] = 1'b0; gpio_pin[3] = 1'b0; settle();
        check("R3 disabled status and flags", msr_b, 8'h00);
        check("R10 pins visible when disabled", gstate & 8'h0F, 8'h02);
        en_b = 1'b1; @(negedge clk); @(negedge clk);
        check("R3 enabling does not flag", msr_b, 8'hE0);
        check("R2 channel B pins 2 3 0", msr_b & 8'hE0, 8'hE0);
        en_b = 1'b0; @(negedge clk); @(negedge clk);
        check("R3 disabling does not flag", msr_b, 8'h00);
        gpio_pin[0] = 1'b1; gpio_pin[2] = 1'b1; gpio_pin[3] = 1'b1; settle();
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        cts_n_a = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_a = 1'b1; #1; v = msr_a;
        @(posedge clk); @(negedge clk); rd_a = 1'b0;
        check("R7 read misses coincident change", v, 8'h10);
        check("R7 coincident change kept", msr_a, 8'h11);
        read_a(v);
        cts_n_a = 1'b1; settle(); read_a(v);
    endtask

    task automatic t_sticky_irq();
        logic [7:0] v;
        cts_n_b = 1'b0; settle();
        repeat (10) @(negedge clk);
        check("R8 flag held", msr_b, 8'h11);
        check("R9 irq off when disabled", {7'd0, irq_b}, 8'h00);
        ie_b = 1'b1; #1;
        check("R9 irq on", {7'd0, irq_b}, 8'h01);
        cts_n_a = 1'b0; settle();
        read_a(v);
        check("R12 B untouched by A read", msr_b, 8'h11);
        read_b(v);
        check("R9 irq cleared by read", {7'd0, irq_b}, 8'h00);
        ie_b = 1'b0;
    endtask

    task automatic t_reset_active();
        cts_n_a = 1'b0;
        do_reset();
        check("R11 active pin through reset no flag", msr_a, 8'h10);
        cts_n_a = 1'b1; settle();
        check("R11 later change flags", msr_a, 8'h01);
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_cts();
        t_shared_a();
        t_ri();
        t_disabled_b();
        t_same_cycle();
        t_sticky_irq();
        t_reset_active();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule